// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block runs an eight-pin general-purpose port. Every pin carries a two-bit drive mode that selects one of four behaviours: quasi-bidirectional, input-only, push-pull or open-drain. The block does not drive the pads itself. For each pin it produces three enables for an external pad cell: a strong pull-down, a strong pull-up and a weak pull-up. The pad cell turns these into electrical drive.

Pin inputs pass through a per-pin glitch filter before any logic sees them. A state register sets the output latches when written. When read, it returns the filtered level of every pin. A fast write path sets the output latches without a register address. A fast read output shows the filtered levels at all times.

A quasi-bidirectional pin holds a latched one with only the weak pull-up. When its latch goes from low to high, the block adds a short strong pull-up pulse so the pin edge rises quickly.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous reset:
  - both configuration registers read 0x55, so every pin is input-only;
  - the output latches hold 0x0F;
  - the filtered levels are 0;
  - all three drive enable vectors are 0.
- R2: The mode code of pin n is 00 quasi-bidirectional, 01 input-only, 10 push-pull, 11 open-drain. Register address 0 holds pins 3..0 and address 1 holds pins 7..4. Within a register, pin n uses bits 2(n mod 4)+1 : 2(n mod 4). Both registers read back what was written.
- R3: A write to address 2, or a fast output write, changes the latch only for pins whose mode is not 01. An input-only pin keeps its latch value, and that value shows once the pin is switched to an output mode.
- R4: An input-only pin asserts none of its three drive enables.
- R5: A push-pull pin asserts strong pull-up when its latch is 1 and strong pull-down when its latch is 0. No pin ever asserts both strong enables at once.
- R6: An open-drain pin asserts strong pull-down when its latch is 0 and never asserts either pull-up.
- R7: A quasi-bidirectional pin works as follows:
  - it asserts the weak pull-up while its latch is 1;
  - it asserts strong pull-down while its latch is 0;
  - after a latch change from 0 to 1 it asserts strong pull-up for exactly PULSE_CYCLES (default 2) clocks, starting in the cycle after the write.
- R8: A pin level held for at least FILT_CYCLES (default 4) clocks appears on the filtered level FILT_CYCLES+1 clocks after the first rising edge that sees it. A level held for fewer than FILT_CYCLES clocks never appears.
- R9: Reading address 2 and the fast read output both return the filtered levels of all pins, whatever their mode. Reading address 3 returns 0.
- R10: When a register write to address 2 and a fast output write happen in the same cycle, the register write sets the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address (0 mode low, 1 mode high, 2 state) |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| out_set_en | input | 1 | Fast output write strobe |
| out_set_data | input | 8 | Fast output write data |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_level | output | 8 | Filtered pin levels (fast read) |
| pull_low | output | 8 | Per-pin strong pull-down enable |
| pull_high | output | 8 | Per-pin strong pull-up enable |
| weak_high | output | 8 | Per-pin weak pull-up enable |

## Verification
The assertions rely on a few properties of the inputs:
- Reset is held for at least one rising edge before it is released.
- `pin_in`, the write strobes and their data change only away from the rising edge.
- A single write strobe addresses one register per cycle.

The bench meets these conditions by driving every input at the falling edge and by raising reset for several cycles at the start. The latch-hold property treats a fast write and a state write as equivalent when deciding whether an input-only pin must stay unchanged, so the bench also exercises both strobes in the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PIN_COUNT    = 8;
    localparam int PINS_PER_CFG = 4;
    localparam int CFG_BITS     = 2 * PIN_COUNT;

    typedef enum logic [1:0] {
        MODE_QUASI     = 2'b00,
        MODE_INPUT     = 2'b01,
        MODE_PUSHPULL  = 2'b10,
        MODE_OPENDRAIN = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        ADDR_CFG_LO = 2'd0,
        ADDR_CFG_HI = 2'd1,
        ADDR_STATE  = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic pull_low;
        logic pull_high;
        logic weak_high;
    } pin_drive_t;

    localparam logic [7:0] CFG_RESET   = 8'h55;
    localparam logic [7:0] STATE_RESET = 8'h0F;

    function automatic logic drives_out(input pin_mode_e m);
        return m != MODE_INPUT;
    endfunction

    function automatic pin_mode_e mode_of(input logic [CFG_BITS-1:0] cfg, input int idx);
        return pin_mode_e'(cfg[2*idx +: 2]);
    endfunction

endpackage

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES - 1);

    logic          samp_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q  <= 1'b0;
            cnt_q   <= '0;
            level_o <= 1'b0;
        end else begin
            samp_q <= raw_i;
            if (samp_q == level_o) begin
                cnt_q <= '0;
            end else if (cnt_q == LIMIT) begin
                level_o <= samp_q;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: the filtered level may only move once the run counter reached its limit
    assert_filter_settled_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_o) |-> ($past(cnt_q) == LIMIT && $past(samp_q) == level_o));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 fast_en,
    input  logic [7:0]           fast_data,
    output logic [CFG_BITS-1:0]  cfg_all,
    output logic [PIN_COUNT-1:0] latch_q,
    output logic [PIN_COUNT-1:0] rise_o
);
    logic [7:0]           cfg_lo_q;
    logic [7:0]           cfg_hi_q;
    logic [PIN_COUNT-1:0] out_mask;
    logic [PIN_COUNT-1:0] latch_d;
    logic                 state_wr;

    assign cfg_all  = {cfg_hi_q, cfg_lo_q};
    assign state_wr = wr_en && (wr_addr == ADDR_STATE);

    always_comb begin
        for (int i = 0; i < PIN_COUNT; i++) begin
            out_mask[i] = drives_out(mode_of(cfg_all, i));
        end
        latch_d = latch_q;
        if (state_wr) begin
            latch_d = (wr_data & out_mask) | (latch_q & ~out_mask);
        end else if (fast_en) begin
            latch_d = (fast_data & out_mask) | (latch_q & ~out_mask);
        end
    end

    assign rise_o = latch_d & ~latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_lo_q <= CFG_RESET;
            cfg_hi_q <= CFG_RESET;
            latch_q  <= STATE_RESET;
        end else begin
            if (wr_en && wr_addr == ADDR_CFG_LO) cfg_lo_q <= wr_data;
            if (wr_en && wr_addr == ADDR_CFG_HI) cfg_hi_q <= wr_data;
            latch_q <= latch_d;
        end
    end

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_hold
        // R3: an input-only pin ignores both output write paths
        assert_input_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
            ((state_wr || fast_en) && cfg_all[2*g +: 2] == MODE_INPUT)
            |=> latch_q[g] == $past(latch_q[g]));
    end

endmodule

// File: rtl/gpio_pin_driver.sv
module gpio_pin_driver
    import gpio_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  pin_mode_e  mode_i,
    input  logic       latch_i,
    input  logic       rise_i,
    output pin_drive_t drv_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [PW-1:0] boost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            boost_q <= '0;
        end else if (rise_i) begin
            boost_q <= PW'(PULSE_CYCLES);
        end else if (boost_q != '0) begin
            boost_q <= boost_q - 1'b1;
        end
    end

    always_comb begin
        drv_o = '0;
        unique case (mode_i)
            MODE_QUASI: begin
                drv_o.pull_low  = ~latch_i;
                drv_o.weak_high = latch_i;
                drv_o.pull_high = latch_i && (boost_q != '0);
            end
            MODE_INPUT: begin
                drv_o = '0;
            end
            MODE_PUSHPULL: begin
                drv_o.pull_low  = ~latch_i;
                drv_o.pull_high = latch_i;
            end
            MODE_OPENDRAIN: begin
                drv_o.pull_low = ~latch_i;
            end
        endcase
    end

    // R5: strong pull-up and strong pull-down never fight
    assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
        !(drv_o.pull_low && drv_o.pull_high));

    // R7: a quasi pin whose latch just rose gets the strong boost
    assert_quasi_boost_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(latch_i) && mode_i == MODE_QUASI) |-> drv_o.pull_high);

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int FILT_CYCLES  = 4,
    parameter int PULSE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [1:0]           rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 out_set_en,
    input  logic [7:0]           out_set_data,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_level,
    output logic [PIN_COUNT-1:0] pull_low,
    output logic [PIN_COUNT-1:0] pull_high,
    output logic [PIN_COUNT-1:0] weak_high
);
    logic [CFG_BITS-1:0]  cfg_all;
    logic [PIN_COUNT-1:0] latch_q;
    logic [PIN_COUNT-1:0] rise;
    logic [PIN_COUNT-1:0] filt_lvl;
    pin_drive_t           drv [PIN_COUNT];

    gpio_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fast_en   (out_set_en),
        .fast_data (out_set_data),
        .cfg_all   (cfg_all),
        .latch_q   (latch_q),
        .rise_o    (rise)
    );

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        gpio_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (pin_in[g]),
            .level_o (filt_lvl[g])
        );

        gpio_pin_driver #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
            .clk     (clk),
            .rst     (rst),
            .mode_i  (pin_mode_e'(cfg_all[2*g +: 2])),
            .latch_i (latch_q[g]),
            .rise_i  (rise[g]),
            .drv_o   (drv[g])
        );

        assign pull_low[g]  = drv[g].pull_low;
        assign pull_high[g] = drv[g].pull_high;
        assign weak_high[g] = drv[g].weak_high;
    end

    assign pin_level = filt_lvl;

    always_comb begin
        unique case (rd_addr)
            ADDR_CFG_LO: rd_data = cfg_all[7:0];
            ADDR_CFG_HI: rd_data = cfg_all[15:8];
            ADDR_STATE:  rd_data = filt_lvl;
            default:     rd_data = 8'h00;
        endcase
    end

endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;

    localparam int K_RD = 0;
    localparam int K_LVL = 1;
    localparam int K_LOW = 2;
    localparam int K_HIGH = 3;
    localparam int K_WEAK = 4;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       out_set_en = 1'b0;
    logic [7:0] out_set_data = 8'h00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_level, pull_low, pull_high, weak_high;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .out_set_en(out_set_en),
        .out_set_data(out_set_data), .pin_in(pin_in), .pin_level(pin_level),
        .pull_low(pull_low), .pull_high(pull_high), .weak_high(weak_high)
    );

    // monitor: compares queued expectations against outputs after each rising edge
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = rd_data;
                K_LVL:   act = pin_level;
                K_LOW:   act = pull_low;
                K_HIGH:  act = pull_high;
                default: act = weak_high;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    // expectation holds after the next rising edge
    task automatic want(input int kind, input logic [7:0] val, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = val;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic drives(input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] wk, input string req);
        want(K_LOW, lo, req);
        want(K_HIGH, hi, req);
        want(K_WEAK, wk, req);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset values
        rd_addr = 2'd0; want(K_RD, 8'h55, "R1"); drives(8'h00, 8'h00, 8'h00, "R1"); tick();
        rd_addr = 2'd1; want(K_RD, 8'h55, "R1"); want(K_LVL, 8'h00, "R1"); tick();
        rd_addr = 2'd2; want(K_RD, 8'h00, "R1"); tick();

        // R2 layout: pin0 input, pin1 quasi, pin2 open-drain, pin3 push-pull
        reg_write(2'd0, 8'hB1);
        rd_addr = 2'd0; want(K_RD, 8'hB1, "R2");
        drives(8'h00, 8'h08, 8'h02, "R2 R4 R5 R6 R7");
        tick();
        rd_addr = 2'd1; want(K_RD, 8'h55, "R2"); tick();

        // R3 state write masked by mode
        reg_write(2'd2, 8'hF0);
        drives(8'h0E, 8'h00, 8'h00, "R3 R6 R7");
        tick();
        reg_write(2'd0, 8'hB2);  // pin0 now push-pull: shows retained latch 1
        reg_write(2'd1, 8'hAA);  // pins 7..4 push-pull: retained latch 0
        drives(8'hFE, 8'h01, 8'h00, "R3");
        tick();

        // R7 quasi boost via fast write, pin1 rises
        out_set_en = 1'b1; out_set_data = 8'h03;
        want(K_HIGH, 8'h03, "R7"); want(K_WEAK, 8'h02, "R7");
        tick();
        out_set_en = 1'b0;
        want(K_HIGH, 8'h03, "R7"); tick();
        want(K_HIGH, 8'h01, "R7"); want(K_LOW, 8'hFC, "R5"); tick();
        want(K_HIGH, 8'h01, "R7"); want(K_WEAK, 8'h02, "R7"); tick();
        out_set_en = 1'b1; out_set_data = 8'h01;
        drives(8'hFE, 8'h01, 8'h00, "R7");
        tick();
        out_set_en = 1'b0;

        // R10 both writes in one cycle: register path wins
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hFF;
        out_set_en = 1'b1; out_set_data = 8'h00;
        drives(8'h00, 8'hFB, 8'h02, "R10 R6");
        tick();
        wr_en = 1'b0; out_set_en = 1'b0;
        tick(); tick();
        want(K_HIGH, 8'hF9, "R7 R6"); tick();

        // R8 filter latency, R9 read paths
        rd_addr = 2'd2;
        pin_in = 8'hA5;
        for (int i = 0; i < 4; i++) begin
            want(K_LVL, 8'h00, "R8");
            tick();
        end
        want(K_LVL, 8'hA5, "R8"); want(K_RD, 8'hA5, "R9");
        tick();

        // R8 glitch of FILT_CYCLES-1 clocks is rejected
        pin_in = 8'h85;
        repeat (3) tick();
        pin_in = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            want(K_LVL, 8'hA5, "R8");
            tick();
        end

        // R8 level held exactly FILT_CYCLES clocks is accepted
        pin_in = 8'hA4;
        for (int i = 0; i < 4; i++) begin
            want(K_LVL, 8'hA5, "R8");
            tick();
        end
        pin_in = 8'hA5;
        want(K_LVL, 8'hA4, "R8");
        tick();
        repeat (10) tick();

        // R9 spare address and mode independence
        rd_addr = 2'd3; want(K_RD, 8'h00, "R9"); tick();
        reg_write(2'd1, 8'h55);
        rd_addr = 2'd2; want(K_RD, 8'hA5, "R9"); want(K_LVL, 8'hA5, "R9");
        want(K_LOW, 8'h00, "R4"); tick();
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule